// File: doc/BRIEF.md
# Configuration Word Streamer

This controller copies a block of configuration words from a configuration memory into the write port of a reconfigurable fabric. The copy runs over a dedicated 32-bit path that is separate from the system bus. A processor starts a load with one write to a control register. That write chooses a full-fabric or a partial-fabric load and gives the first memory address. The processor then polls a status register until the done flag appears.

Once a load starts, the controller runs on its own. It drives the memory read enable and the address counter. It also drives the fabric chip select and the fabric write strobe. It moves one word per system clock. The number of cycles from start to done is fixed: the word count of the chosen mode plus two cycles. One of these cycles opens the chip select and one closes it. The word count for each mode is a parameter. The default full load is 191492 words and the default partial load is 95746 words.

Top module: `cfg_loader`

## Requirements
- R1: During and after reset, fab_cs, fab_we and mem_rd are low, and the status register reads busy=0 and done=0.
- R2: A register write with reg_sel=0 and bit 0 set, while idle, starts a load. The status register then reads busy=1 and done=0 from the cycle after that edge until the load ends.
- R3: Bit 1 of the control write selects the mode: 0 gives FULL_WORDS write strobes and 1 gives PART_WORDS write strobes. The mode shows as status bit 2.
- R4: mem_rd is high for exactly one run of N consecutive cycles. mem_addr starts at the control write's bits [AW+7:8] and rises by one each cycle, wrapping modulo 2^AW.
- R5: fab_we is high only in cycles that carry a valid word. fab_data in the k-th strobe cycle is the memory word at address base+k-1, which a read memory returns one cycle after its read.
- R6: fab_cs rises one cycle before the first strobe and falls one cycle after the last strobe.
- R7: busy clears and done sets on the same edge that drops fab_cs, which is N+2 cycles after the start edge.
- R8: A start write issued while busy is ignored: the running load keeps its mode, address sequence and length.
- R9: A control write with bit 0 clear starts nothing. It leaves the status register and the control readback unchanged.
- R10: done stays set until the next accepted start, and that start clears it.
- R11: Reading with reg_sel=0 returns the last accepted start address in bits [AW+7:8] and its mode in bit 1. Reading with reg_sel=1 returns busy in bit 0, done in bit 1 and mode in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, shared by the transfer |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| mem_rd | output | 1 | Configuration memory read enable |
| mem_addr | output | AW | Configuration memory word address |
| mem_rdata | input | 32 | Memory word, one cycle after the read |
| fab_cs | output | 1 | Fabric chip select |
| fab_we | output | 1 | Fabric write strobe |
| fab_data | output | 32 | Fabric configuration word |

## Verification
The assertions assume that the memory has a read latency of exactly one cycle. They also assume that reset is held for at least one edge before any register write, and that the two word-count parameters are at least one. The bench's memory model returns a word computed from the address on the edge after each read, so this latency holds by construction. The random stimulus draws modes, start addresses (including some near the top of the address range) and the cycle at which a second start is issued. Every second start falls inside the busy window, so every such write lands while the controller is busy.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int FULL_WORDS = 191492,
  parameter int PART_WORDS = 95746,
  parameter int AW         = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_rdata,
  output logic          fab_cs,
  output logic          fab_we,
  output logic [31:0]   fab_data
);
  localparam int MAXW = (FULL_WORDS > PART_WORDS) ? FULL_WORDS : PART_WORDS;
  localparam int CW   = $clog2(MAXW) + 1;

  logic          busy_q, done_q, cs_q, rd_q, we_q, mode_q;
  logic [AW-1:0] addr_q, base_q;
  logic [CW-1:0] left_q;
  logic [31:0]   ctrl_view, stat_view;

  wire unused_bits = ^reg_wdata[7:2];

  wire go = reg_wr && !reg_sel && reg_wdata[0] && !busy_q;
  wire [CW-1:0] len_m1 = reg_wdata[1] ? CW'(PART_WORDS - 1) : CW'(FULL_WORDS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cs_q   <= 1'b0;
      rd_q   <= 1'b0;
      we_q   <= 1'b0;
      mode_q <= 1'b0;
      addr_q <= '0;
      base_q <= '0;
      left_q <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cs_q   <= 1'b1;
      rd_q   <= 1'b1;
      we_q   <= 1'b0;
      mode_q <= reg_wdata[1];
      base_q <= reg_wdata[8 +: AW];
      addr_q <= reg_wdata[8 +: AW];
      left_q <= len_m1;
    end else if (busy_q) begin
      we_q <= rd_q;
      if (rd_q) begin
        if (left_q == '0) begin
          rd_q <= 1'b0;
        end else begin
          left_q <= left_q - CW'(1);
          addr_q <= addr_q + AW'(1);
        end
      end
      if (!rd_q && !we_q) begin
        cs_q   <= 1'b0;
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[8 +: AW] = base_q;
    ctrl_view[1] = mode_q;
    stat_view = {29'd0, mode_q, done_q, busy_q};
  end

  assign reg_rdata = reg_sel ? stat_view : ctrl_view;
  assign mem_rd    = rd_q;
  assign mem_addr  = addr_q;
  assign fab_cs    = cs_q;
  assign fab_we    = we_q;
  assign fab_data  = mem_rdata;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          fab_we,
  input logic          fab_cs,
  input logic          busy_q,
  input logic          done_q
);
  a_r5_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    fab_we |-> fab_cs);

  a_r5_read_then_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> fab_we);

  a_r5_strobe_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_we && !mem_rd) |=> !fab_we);

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  a_r6_cs_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fab_cs) |-> (mem_rd && !fab_we));

  a_r6_cs_tail: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fab_cs) |-> $past(fab_cs && !fab_we && !mem_rd));

  a_r2_cs_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fab_cs |-> busy_q);

  a_r7_done_excl_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));

  a_r7_end_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
endmodule

bind cfg_loader cfg_loader_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_cfg_loader.sv
`timescale 1ns/1ps
module sim_cfg_loader;
  localparam int FW = 40;
  localparam int PW = 17;
  localparam int AW = 24;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, reg_wr, reg_sel;
  logic [31:0]   reg_wdata, reg_rdata, mem_q, fab_data;
  logic          mem_rd, fab_cs, fab_we;
  logic [AW-1:0] mem_addr;

  cfg_loader #(.FULL_WORDS(FW), .PART_WORDS(PW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_q), .fab_cs(fab_cs),
    .fab_we(fab_we), .fab_data(fab_data));

  function automatic logic [31:0] pat(input logic [AW-1:0] a);
    return {8'hC3, a} ^ (32'(a) * 32'h0001_9E37);
  endfunction

  initial mem_q = '0;
  always @(posedge clk) if (mem_rd) mem_q <= pat(mem_addr);

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  function automatic logic [31:0] ctrl_word(input logic part, input logic [AW-1:0] base, input logic st);
    logic [31:0] w;
    w = '0;
    w[8 +: AW] = base;
    w[1] = part;
    w[0] = st;
    return w;
  endfunction

  task automatic xfer(input logic part, input logic [AW-1:0] base, input int poke);
    int n, nwe;
    int e_cs, e_we, e_rd, e_ad, e_dt, e_st;
    logic [AW-1:0] a;
    n = part ? PW : FW;
    nwe = 0; e_cs = 0; e_we = 0; e_rd = 0; e_ad = 0; e_dt = 0; e_st = 0;
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = ctrl_word(part, base, 1'b1);
    for (int k = 0; k <= n + 3; k++) begin
      @(negedge clk);
      if (fab_cs !== (k <= n + 1)) e_cs++;
      if (fab_we !== (k >= 1 && k <= n)) e_we++;
      if (fab_we) nwe++;
      if (mem_rd !== (k <= n - 1)) e_rd++;
      a = base + AW'(k);
      if (mem_rd && mem_addr !== a) e_ad++;
      if (fab_we && fab_data !== pat(base + AW'(k - 1))) e_dt++;
      if (reg_sel && reg_rdata[2:0] !== {part, (k >= n + 2), (k <= n + 1)}) e_st++;
      if (k == poke) begin
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = ctrl_word(~part, base + AW'(99), 1'b1);
      end else begin
        reg_wr = 1'b0; reg_sel = 1'b1;
      end
    end
    chk("R3 strobe count", nwe, n);
    chk("R4 read window", e_rd, 0);
    chk("R4 address sequence", e_ad, 0);
    chk("R5 strobe window and data", e_we + e_dt, 0);
    chk("R6 chip select window", e_cs, 0);
    chk("R2 R7 status timing", e_st, 0);
    if (poke >= 0) chk("R8 start while busy ignored", e_cs + e_we + e_ad + nwe - n, 0);
  endtask

  initial begin
    void'($urandom(32'd7));
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b1; reg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {fab_cs, fab_we, mem_rd}, 3'b000);
    chk("R1 reset status", reg_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: write with start bit clear
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = ctrl_word(1'b1, 24'h000123, 1'b0);
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 no start outputs", {fab_cs, mem_rd}, 2'b00);
    chk("R9 control readback unchanged", reg_rdata, 32'd0);
    reg_sel = 1'b1; #1;
    chk("R9 status unchanged", reg_rdata, 32'd0);

    xfer(1'b0, 24'h000100, -1);
    xfer(1'b1, 24'hFFFFF8, 3);
    repeat (5) @(negedge clk);
    reg_sel = 1'b1; #1;
    chk("R10 R11 done persists status", reg_rdata, 32'd6);
    reg_sel = 1'b0; #1;
    chk("R11 control readback", reg_rdata, ctrl_word(1'b1, 24'hFFFFF8, 1'b0));

    for (int i = 0; i < 8; i++) begin
      logic p;
      logic [AW-1:0] b;
      int pk;
      p  = 1'($urandom % 2);
      b  = (i % 3 == 0) ? AW'(24'hFFFFFF - ($urandom % 8)) : AW'($urandom);
      pk = ($urandom % 2 == 0) ? int'(1 + $urandom % 12) : -1;
      xfer(p, b, pk);
      reg_sel = 1'b0; #1;
      chk("R11 readback after random load", reg_rdata, ctrl_word(p, b, 1'b0));
    end

    // R10: done survives a write without start, cleared by next start
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = ctrl_word(1'b0, 24'h0, 1'b0);
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b1; #1;
    chk("R10 done kept", reg_rdata[1:0], 2'b10);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = ctrl_word(1'b0, 24'h10, 1'b1);
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b1; #1;
    chk("R10 done cleared by start", reg_rdata[2:0], 3'b001);
    repeat (FW + 4) @(negedge clk);
    chk("R7 full load finished", reg_rdata[2:0], 3'b010);

    finish_run();
  end
endmodule